// File: doc/BRIEF.md
# Flow-Controlled Serial Byte Transmitter

This block serialises 8-bit characters onto a single asynchronous line. A producer hands bytes over through a valid/ready handshake into a four-entry queue. The frame engine drains the queue one character at a time. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts sixteen pulses of an external baud tick.

A remote receiver throttles the sender through an active-low clear-to-send input, `cts_n`. This input passes through a two-flop synchroniser. It is consulted only at the moment a new character would be launched. Once a character's start bit has gone out, the character is always finished through its stop bit, whatever `cts_n` does. If the synchronised input is high when the engine is ready for the next character, the engine parks in a hold state and keeps the line at mark level. When `cts_n` returns low, the engine sends the next queued byte.

The engine has five named states:
- **IDLE**: the line is at mark and the queue is empty.
- **HOLD**: a byte is waiting but clear-to-send is withdrawn.
- **START**: the start bit is on the line.
- **DATA**: the eight data bits are on the line.
- **STOP**: the stop bit is on the line.

Every transition is taken on a baud tick:
- **launch** (IDLE or HOLD to START): a byte is queued and clear-to-send is given. The byte is popped.
- **park** (IDLE to HOLD): a byte is queued but clear-to-send is withdrawn.
- **release** (HOLD to IDLE): the queue has become empty.
- **begin-data** (START to DATA): the sixteenth tick of the start bit.
- **next-bit** (DATA to DATA): the sixteenth tick of a data bit other than the last.
- **end-data** (DATA to STOP): the sixteenth tick of the eighth data bit.
- **finish** (STOP to IDLE): the sixteenth tick of the stop bit.

Top module: `uart_cts_tx`

## Requirements
- R1: While reset is asserted and immediately after it is released, `txd` is 1, `wr_ready` is 1 and `tx_busy` is 0.
- R2: Each character is sent as one 0 start bit, then data bits 0 to 7 in that order, then one 1 stop bit.
- R3: Every bit occupies exactly 16 baud ticks, and the line changes only in a clock cycle that follows a cycle with `baud_tick` high.
- R4: The queue holds up to 4 bytes. `wr_ready` is 0 while 4 bytes are waiting, and a `wr_valid` presented while `wr_ready` is 0 is ignored: the byte is never transmitted.
- R5: Accepted bytes are transmitted in the order they were accepted.
- R6: A character whose start bit has begun is completed through its stop bit even if `cts_n` goes high during it.
- R7: While the synchronised `cts_n` is high, no start bit is issued, `txd` stays 1 and `tx_busy` stays 0, even with bytes waiting.
- R8: When `cts_n` returns low, transmission resumes with a start bit and the next queued byte.
- R9: `tx_busy` is 1 from the first clock of a start bit through the last clock of the stop bit, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Byte offered for transmission |
| wr_valid | input | 1 | Producer has a byte on `wr_data` |
| wr_ready | output | 1 | Queue can accept a byte this cycle |
| baud_tick | input | 1 | One pulse per sixteenth of a bit time |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txd | output | 1 | Serial line, idles at 1 |
| tx_busy | output | 1 | A frame is on the line |

## Verification
All 256 byte values are sent back to back with the tick held high. This separates bit-order and framing faults from queue-order faults, because every data pattern is decoded against the write order. A lone 0xFF frame is timed at two tick rates, where the only low pulse is the start bit, so bit-length and tick-gating errors show up as a wrong pulse width.

Four bytes written while clear-to-send is withdrawn fill the queue. A fifth write is then refused, which exposes capacity and backpressure faults. Dropping clear-to-send partway through a frame tells apart an engine that aborts the frame from one that finishes it and then holds. Restoring clear-to-send shows whether the next byte resumes in order.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HOLD,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // resets to the deasserted (high) level so nothing launches early
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slot_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) slot_q[wr_ptr_q] <= push_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_i) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
            unique case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_o  = slot_q[rd_ptr_q];
    assign full_o  = (count_q == CW'(DEPTH));
    assign empty_o = (count_q == '0);

    // R5: the frame engine never takes a byte from an empty queue
    p_no_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    // R4: occupancy never exceeds the queue depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_cts_tx_pkg::*;
#(
    parameter int W     = 8,
    parameter int TICKS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         clear_i,
    input  logic         have_data_i,
    input  logic [W-1:0] data_i,
    output logic         pop_o,
    output logic         txd_o,
    output logic         busy_o
);

    localparam int CNT_W = $clog2(TICKS);
    localparam int IDX_W = $clog2(W);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [W-1:0]     shreg_q, shreg_d;

    logic bit_end;
    assign bit_end = tick_i && (cnt_q == CNT_W'(TICKS - 1));

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        shreg_d = shreg_q;
        pop_o   = 1'b0;
        unique case (state_q)
            TX_IDLE, TX_HOLD: begin
                if (tick_i) begin
                    if (have_data_i && clear_i) begin
                        state_d = TX_START;
                        shreg_d = data_i;
                        cnt_d   = '0;
                        pop_o   = 1'b1;
                    end else if (have_data_i) begin
                        state_d = TX_HOLD;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end
            end
            TX_START: begin
                if (tick_i) cnt_d = cnt_q + 1'b1;
                if (bit_end) begin
                    state_d = TX_DATA;
                    cnt_d   = '0;
                    idx_d   = '0;
                end
            end
            TX_DATA: begin
                if (tick_i) cnt_d = cnt_q + 1'b1;
                if (bit_end) begin
                    cnt_d   = '0;
                    shreg_d = shreg_q >> 1;
                    if (idx_q == IDX_W'(W - 1)) state_d = TX_STOP;
                    else                        idx_d   = idx_q + 1'b1;
                end
            end
            TX_STOP: begin
                if (tick_i) cnt_d = cnt_q + 1'b1;
                if (bit_end) begin
                    state_d = TX_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            shreg_q <= shreg_d;
        end
    end

    // outputs
    always_comb begin
        txd_o  = 1'b1;
        busy_o = 1'b0;
        unique case (state_q)
            TX_START: begin txd_o = 1'b0;       busy_o = 1'b1; end
            TX_DATA:  begin txd_o = shreg_q[0]; busy_o = 1'b1; end
            TX_STOP:  begin txd_o = 1'b1;       busy_o = 1'b1; end
            default:  begin txd_o = 1'b1;       busy_o = 1'b0; end
        endcase
    end

    // R7: a start bit is only entered when clear-to-send was given
    p_start_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_START && $past(state_q) != TX_START) |-> $past(clear_i));

    // R3: without a tick the line holds its level
    p_hold_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(txd_o));

    // R6: withdrawing clear-to-send never aborts the data phase
    p_frame_finishes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && !clear_i) |=> (state_q == TX_DATA || state_q == TX_STOP));

endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx #(
    parameter int DATA_W      = 8,
    parameter int QUEUE_DEPTH = 4,
    parameter int BIT_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic              baud_tick,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_busy
);

    logic              cts_n_sync;
    logic              q_full, q_empty, q_pop;
    logic [DATA_W-1:0] q_head;

    cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cts_n),
        .sync_o  (cts_n_sync)
    );

    tx_queue #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_valid && wr_ready),
        .push_data_i (wr_data),
        .pop_i       (q_pop),
        .head_o      (q_head),
        .full_o      (q_full),
        .empty_o     (q_empty)
    );

    tx_frame_fsm #(.W(DATA_W), .TICKS(BIT_TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (baud_tick),
        .clear_i     (!cts_n_sync),
        .have_data_i (!q_empty),
        .data_i      (q_head),
        .pop_o       (q_pop),
        .txd_o       (txd),
        .busy_o      (tx_busy)
    );

    assign wr_ready = !q_full;

    // R9: whenever no frame is in flight the line sits at mark
    p_busy_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

endmodule

// File: tb/uart_cts_tx_tb.sv
module uart_cts_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b0;
    logic       wr_ready;
    logic       baud_tick = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd;
    logic       tx_busy;

    int checks = 0;
    int fails  = 0;
    int tick_per = 1;
    int tick_ph  = 0;

    logic [7:0] exp_q[$];
    int   rx_count = 0;
    bit   rx_active = 0;
    int   rx_cnt = 0;
    logic [7:0] rx_byte;
    int   low_run = 0;
    int   last_low = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    uart_cts_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .baud_tick(baud_tick), .cts_n(cts_n),
        .txd(txd), .tx_busy(tx_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // baud tick generator
    always @(negedge clk) begin
        if (tick_per <= 1) baud_tick <= 1'b1;
        else begin
            baud_tick <= (tick_ph == 0);
            tick_ph   <= (tick_ph + 1) % tick_per;
        end
    end

    // line monitor: decodes frames by clock counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (txd == 1'b0) low_run++;
            else if (low_run != 0) begin last_low = low_run; low_run = 0; end

            if (!rx_active) begin
                if (txd == 1'b0) begin rx_active = 1; rx_cnt = 0; end
            end else begin
                int bc;
                int k;
                bc = 16 * tick_per;
                rx_cnt++;
                if (rx_cnt >= bc / 2 && (rx_cnt - bc / 2) % bc == 0) begin
                    k = (rx_cnt - bc / 2) / bc;
                    chk(tx_busy == 1'b1, "R9 busy mid-frame", tx_busy, 1);
                    if (k == 0) chk(txd == 1'b0, "R2 start bit", txd, 0);
                    else if (k <= 8) rx_byte[k-1] = txd;
                    else begin
                        chk(txd == 1'b1, "R2 stop bit", txd, 1);
                        if (exp_q.size() == 0) chk(0, "R5 unexpected frame", rx_byte, -1);
                        else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(rx_byte == e, "R2/R5 byte order and value", rx_byte, e);
                        end
                        rx_count++;
                        rx_active = 0;
                    end
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        exp_q.push_back(b);
    endtask

    task automatic wait_rx(input int n);
        while (rx_count < n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(txd == 1'b1, "R1 txd in reset", txd, 1);
        chk(wr_ready == 1'b1, "R1 ready in reset", wr_ready, 1);
        chk(tx_busy == 1'b0, "R1 busy in reset", tx_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1 && wr_ready && !tx_busy, "R1 after release", {txd, wr_ready, tx_busy}, 3'b110);

        // R3: bit length, tick every clock: only low pulse is the start bit
        put(8'hFF);
        wait_rx(1);
        chk(last_low == 16, "R3 start bit length at tick/1", last_low, 16);

        // R3: tick every 4th clock
        tick_per = 4;
        repeat (8) @(negedge clk);
        put(8'hFF);
        wait_rx(2);
        chk(last_low >= 61 && last_low <= 64, "R3 start bit length at tick/4", last_low, 64);
        tick_per = 1;
        repeat (8) @(negedge clk);

        // R2/R5: exhaustive sweep of all byte values
        for (int v = 0; v < 256; v++) put(v[7:0]);
        wait_rx(258);
        chk(exp_q.size() == 0, "R5 sweep drained", exp_q.size(), 0);

        // R4/R7: fill queue while clear-to-send withdrawn
        cts_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int v = 0; v < 4; v++) put(8'hA0 + v[7:0]);
        @(negedge clk);
        chk(wr_ready == 1'b0, "R4 ready low when full", wr_ready, 0);
        wr_valid = 1'b1;
        wr_data  = 8'h99;
        repeat (5) @(negedge clk);
        wr_valid = 1'b0;
        begin
            int highs;
            highs = 0;
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                if (txd && !tx_busy) highs++;
            end
            chk(highs == 200, "R7 line held while paused", highs, 200);
        end
        chk(rx_count == 258, "R7 no frame while paused", rx_count, 258);

        // R8: resume, 4 bytes in order, the refused byte absent (R4)
        cts_n = 1'b0;
        wait_rx(262);
        repeat (400) @(negedge clk);
        chk(rx_count == 262, "R4 refused byte not sent", rx_count, 262);
        chk(exp_q.size() == 0, "R8 resumed all queued", exp_q.size(), 0);

        // R6: drop clear-to-send mid-frame
        put(8'h5A);
        put(8'hC3);
        while (!tx_busy) @(negedge clk);
        repeat (40) @(negedge clk);
        cts_n = 1'b1;
        wait_rx(263);
        chk(rx_count == 263, "R6 frame in flight completed", rx_count, 263);
        repeat (600) @(negedge clk);
        chk(rx_count == 263, "R7 next byte held", rx_count, 263);
        chk(txd == 1'b1 && tx_busy == 1'b0, "R7 idle while held", {txd, tx_busy}, 2'b10);
        cts_n = 1'b0;
        wait_rx(264);
        chk(exp_q.size() == 0, "R8 held byte sent on resume", exp_q.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule